// File: doc/BRIEF.md
# Multi-Modulus Streaming Modular Adder

This block adds two residues element by element and reduces the sum modulo a prime. It accepts one operand pair on every clock and produces the sum, reduced modulo the chosen modulus, a fixed two cycles later. Each element carries a small select code. The code picks its modulus from a four-entry on-chip table, so one stream can mix elements that belong to different moduli. The modulus is therefore a run-time choice, not a constant built into the logic.

Both operands must already be reduced, that is, strictly smaller than the selected modulus. The first stage forms the sum one bit wider than the operands and reads the table. The second stage compares the sum against the modulus and subtracts the modulus once when needed. The input side has a valid flag and no backpressure.

The table is written through a plain address/data/enable port. Normal use loads it while the stream is idle. A write that lands in the same cycle as an element reading that entry has a defined outcome, given in R8. The operand width is a parameter, and both 48-bit and 64-bit builds are intended.

Top module: `modadd_mm`

## Requirements
- R1: While `rst` is high, and on the first cycle after it has been high, `out_valid` is 0 and `out_data` is 0. Elements that are in flight when reset arrives never appear at the output.
- R2: `out_valid` is `in_valid` delayed by exactly two clock cycles. A new pair is accepted on every cycle.
- R3: When a + b < q, the output equals a + b, where q is the table entry chosen by `in_sel`.
- R4: When a + b >= q, the output equals a + b - q. The case a + b = q gives 0.
- R5: The result is correct when a + b exceeds 2^DATA_W. The carry of the addition is kept.
- R6: Every element uses the table entry chosen by its own `in_sel`, also when consecutive elements carry different selects.
- R7: When `tab_we` is high, `tab_data` is written to entry `tab_addr`. Elements accepted on any later cycle use the new value.
- R8: An element accepted in the same cycle as a write to its own entry uses the value that entry held before the write.
- R9: `out_data` keeps its last value on every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sel | input | SEL_W | Index of the modulus table entry for this element |
| in_a | input | DATA_W | First operand, less than the selected modulus |
| in_b | input | DATA_W | Second operand, less than the selected modulus |
| tab_we | input | 1 | Write enable for the modulus table |
| tab_addr | input | SEL_W | Modulus table entry to write |
| tab_data | input | DATA_W | Modulus value to write |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | DATA_W | Reduced sum |

## Verification
A table write and a datapath read of the same entry can fall in the same cycle. The bench provokes this by issuing a write to entry 3 together with an element that selects entry 3. The operands are chosen so that the old and the new modulus give different results. The reference model computes that element from the table contents before the write and only then applies the write. The element after it must then see the new value.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
  // Number of modulus entries addressed by a select of the given width.
  function automatic int unsigned table_depth(input int unsigned sel_w);
    return 32'd1 << sel_w;
  endfunction
endpackage

// File: rtl/modadd_modtab.sv
module modadd_modtab #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [SEL_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_val
);
  localparam int unsigned DEPTH = modadd_pkg::table_depth(SEL_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // The read is registered and returns the old contents on a write to the same entry.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_val;
    rd_val <= mem[rd_addr];
  end
endmodule

// File: rtl/modadd_sum_stage.sv
module modadd_sum_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              vld_o,
  output logic [DATA_W:0]   sum_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      sum_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) sum_o <= SUM_W'(a_i) + SUM_W'(b_i);
    end
  end
endmodule

// File: rtl/modadd_reduce_stage.sv
module modadd_reduce_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W:0]   sum_i,
  input  logic [DATA_W-1:0] q_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned DIFF_W = DATA_W + 2;

  logic [DIFF_W-1:0] diff;
  logic              at_or_above;
  logic [DATA_W-1:0] picked;

  always_comb begin
    diff        = DIFF_W'(sum_i) - DIFF_W'(q_i);
    at_or_above = ~diff[DIFF_W-1];
    picked      = at_or_above ? diff[DATA_W-1:0] : sum_i[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= picked;
    end
  end
endmodule

// File: rtl/modadd_mm.sv
module modadd_mm #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              tab_we,
  input  logic [SEL_W-1:0]  tab_addr,
  input  logic [DATA_W-1:0] tab_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              v_s1;
  logic [DATA_W:0]   sum_s1;
  logic [DATA_W-1:0] q_s1;

  modadd_modtab #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_tab (
    .clk     (clk),
    .wr_en   (tab_we),
    .wr_addr (tab_addr),
    .wr_val  (tab_data),
    .rd_addr (in_sel),
    .rd_val  (q_s1)
  );

  modadd_sum_stage #(.DATA_W(DATA_W)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .vld_i (in_valid),
    .a_i   (in_a),
    .b_i   (in_b),
    .vld_o (v_s1),
    .sum_o (sum_s1)
  );

  modadd_reduce_stage #(.DATA_W(DATA_W)) u_red (
    .clk   (clk),
    .rst   (rst),
    .vld_i (v_s1),
    .sum_i (sum_s1),
    .q_i   (q_s1),
    .vld_o (out_valid),
    .res_o (out_data)
  );
endmodule

// File: rtl/modadd_mm_chk.sv
module modadd_mm_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] q_s1
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R1: reset empties the output
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R2: valid comes out two cycles after it goes in
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R4: a result is always below the modulus it was reduced by
  a_r4_below_modulus: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && out_valid) |-> (out_data < $past(q_s1)));

  // R9: output data is held while no result is valid
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_data));
endmodule

bind modadd_mm modadd_mm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .q_s1      (q_s1)
);

// File: tb/tb_modadd_mm.sv
module tb_modadd_mm;
  localparam int unsigned DW = 64;
  localparam int unsigned SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sel = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic          tab_we = 1'b0;
  logic [SW-1:0] tab_addr = '0;
  logic [DW-1:0] tab_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #2ns clk = ~clk;

  modadd_mm #(.DATA_W(DW), .SEL_W(SW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_a(in_a), .in_b(in_b), .tab_we(tab_we), .tab_addr(tab_addr),
    .tab_data(tab_data), .out_valid(out_valid), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;

  // Reference model state
  logic [DW-1:0] mtab [4];
  logic          p1_v = 1'b0, p2_v = 1'b0;
  logic [DW-1:0] p1_d = '0, p2_d = '0;
  string         p1_t = "R2", p2_t = "R2";
  logic [DW-1:0] last_d = '0;

  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, b, q);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, q}) s = s - {1'b0, q};
    return s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] rnd_below(input logic [DW-1:0] q);
    logic [DW-1:0] r;
    r = {$urandom, $urandom};
    return r % q;
  endfunction

  task automatic step(input logic v, input logic [SW-1:0] s,
                      input logic [DW-1:0] a, b,
                      input logic we, input logic [SW-1:0] wa,
                      input logic [DW-1:0] wd, input logic r, input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== p2_v) begin
      errors++;
      $display("FAIL R2 (%s): out_valid actual=%0b expected=%0b", p2_t, out_valid, p2_v);
    end
    checks++;
    if (p2_v) begin
      if (out_data !== p2_d) begin
        errors++;
        $display("FAIL %s: out_data actual=%0h expected=%0h", p2_t, out_data, p2_d);
      end
      last_d = p2_d;
    end else if (out_data !== last_d) begin
      errors++;
      $display("FAIL R9 (%s): held out_data actual=%0h expected=%0h", p2_t, out_data, last_d);
    end
    p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
    p1_v = v & ~r;
    p1_d = ref_add(a, b, mtab[s]);   // old table contents: R8
    p1_t = tag;
    if (we) mtab[wa] = wd;
    if (r) begin
      p1_v = 1'b0; p2_v = 1'b0; p2_t = "R1"; last_d = '0;
    end
    rst = r; in_valid = v; in_sel = s; in_a = a; in_b = b;
    tab_we = we; tab_addr = wa; tab_data = wd;
  endtask

  task automatic elem(input logic [SW-1:0] s, input logic [DW-1:0] a, b, input string tag);
    step(1'b1, s, a, b, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic twrite(input logic [SW-1:0] wa, input logic [DW-1:0] wd);
    step(1'b0, '0, '0, '0, 1'b1, wa, wd, 1'b0, "R7");
  endtask

  initial begin
    logic [1:0] ps;
    for (int i = 0; i < 4; i++) mtab[i] = 64'd1;
    repeat (2) @(posedge clk);
    // R1: reset state
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, "R1");
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, "R1");
    idle("R1");
    // Load table while idle (R7)
    twrite(2'd0, 64'hFFFF_FFFF_FFFF_FFC5);
    twrite(2'd1, 64'h1FFF_FFFF_FFFF_FFFF);
    twrite(2'd2, 64'd97);
    twrite(2'd3, 64'd1000000007);
    idle("R2");
    // R3, R4 with small modulus
    elem(2'd2, 64'd40, 64'd50, "R3");
    elem(2'd2, 64'd50, 64'd47, "R4");
    elem(2'd2, 64'd96, 64'd96, "R4");
    elem(2'd2, 64'd0, 64'd0, "R3");
    // R5: carry beyond DW bits
    elem(2'd0, 64'hFFFF_FFFF_FFFF_FFC4, 64'hFFFF_FFFF_FFFF_FFC4, "R5");
    elem(2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R5");
    elem(2'd0, 64'hFFFF_FFFF_FFFF_FFC4, 64'd1, "R4");
    idle("R2");
    // R6: a different select on every element
    for (int i = 0; i < 24; i++) begin
      ps = 2'(i % 4);
      elem(ps, rnd_below(mtab[ps]), rnd_below(mtab[ps]), "R6");
    end
    // R9 and R2: gaps between elements
    for (int i = 0; i < 12; i++) begin
      ps = 2'(i % 4);
      elem(ps, rnd_below(mtab[ps]), rnd_below(mtab[ps]), "R2");
      idle("R9");
      if (i % 3 == 0) idle("R9");
    end
    // R7: rewrite entry 2, use it on the very next cycle
    twrite(2'd2, 64'd101);
    elem(2'd2, 64'd100, 64'd1, "R7");
    // R8: write and read entry 3 in the same cycle
    step(1'b1, 2'd3, 64'd1000000006, 64'd5, 1'b1, 2'd3, 64'd13, 1'b0, "R8");
    elem(2'd3, 64'd10, 64'd5, "R7");
    elem(2'd3, 64'd12, 64'd1, "R7");
    // Mixed burst
    for (int i = 0; i < 150; i++) begin
      ps = 2'($urandom % 4);
      if ($urandom % 5 == 0) idle("R2");
      else elem(ps, rnd_below(mtab[ps]), rnd_below(mtab[ps]), "R6");
    end
    // R1: reset while elements are in flight
    elem(2'd1, rnd_below(mtab[1]), rnd_below(mtab[1]), "R6");
    elem(2'd1, rnd_below(mtab[1]), rnd_below(mtab[1]), "R6");
    step(1'b1, 2'd1, 64'd3, 64'd4, 1'b0, '0, '0, 1'b1, "R1");
    idle("R1");
    idle("R1");
    elem(2'd2, 64'd60, 64'd60, "R4");
    repeat (4) idle("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2: watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule